// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Register

This block is the per-processor command register through which software sends an interrupt message to other processors. Software writes it as one 64-bit command split over two 32-bit memory-mapped halves. The upper half (byte offset 0x310) only stores the destination byte. The lower half (byte offset 0x300) holds the vector, delivery mode, destination mode, level and shorthand fields. A write to the lower half is the trigger that launches the message.

The block turns the shorthand and the destination into a per-processor target mask over N processor IDs, where N is a parameter. It holds the message on a valid/ready pair until the fabric accepts it, and shows a busy flag in the lower half while the message waits. For a start-up message it also gives the 4 KB-aligned start address that the targets begin executing from.

The sender's own ID is a static input. Processor reset behaviour and arbitration between senders are handled outside the block.

Top module: `ipi_cmd_reg`

## Requirements
- R1: After reset `msg_valid` is 0, both halves read back 0, the busy bit (bit 12 of the low half) reads 0, and `start_addr` is 0.
- R2: A write to offset 0x310 stores `wr_data[31:24]` as the destination, which reads back in bits [31:24] of that offset. The write launches no message.
- R3: A write to offset 0x300 while not busy launches a message. From the next cycle `msg_valid` is 1 and the busy bit reads 1. The message fields come from the low half: `msg_vector` from bits [7:0], `msg_mode` from bits [10:8] (000 fixed, 101 INIT, 110 STARTUP), `msg_logical` from bit 11 and `msg_level` from bit 14. The low half reads back bits 7:0, 10:8, 11, 14 and 19:18 as written, with bit 12 as busy.
- R4: `msg_valid` and every message field stay constant until a cycle where `msg_ready` is 1. In the cycle after that acceptance, `msg_valid` is 0 and the busy bit reads 0.
- R5: A write to offset 0x300 while busy is ignored. The pending message and the low-half readback do not change.
- R6: Shorthand 11 (bits [19:18]) sets a target bit for every processor except `self_id`.
- R7: Shorthand 10 targets all N processors. Shorthand 01 targets only `self_id`.
- R8: With shorthand 00 and bit 11 clear, the destination byte is a processor ID. An ID below N targets that processor alone, 0xFF targets all N processors, and any other ID targets none.
- R9: With shorthand 00 and bit 11 set, the destination byte is a logical bit mask: target bit i equals destination bit i.
- R10: For a STARTUP message, `start_addr` equals the vector shifted left by 12 bits (vector 0x11 gives 0x11000). For any other mode it is 0.
- R11: A write to any offset other than 0x300 or 0x310 changes no state and launches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| self_id | input | ID_W | Static ID of this processor |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Byte offset of the combinational read |
| rd_data | output | 32 | Read data |
| msg_valid | output | 1 | Message pending on the fabric |
| msg_ready | input | 1 | Fabric accepts the message this cycle |
| msg_vector | output | 8 | Interrupt vector |
| msg_mode | output | 3 | Delivery mode |
| msg_logical | output | 1 | Destination was interpreted as a logical mask |
| msg_level | output | 1 | Level assert bit |
| msg_targets | output | N | Per-processor target mask |
| start_addr | output | 20 | Start address for STARTUP messages, else 0 |

## Verification
Some properties are checked by assertions on every cycle. A pending message holds its valid flag and target mask until it is accepted. A busy trigger leaves the stored command untouched. No message starts without a low-half write. An all-but-self mask never contains the sender, and a self-only mask has exactly one bit set.

Other behaviour needs the bench's scenarios to show it. These are the exact mask for each shorthand and destination combination, including out-of-range IDs and the logical mask, the start-address arithmetic, the readback layout, and the fact that writes to other offsets have no effect.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
   localparam logic [2:0] MODE_FIXED   = 3'b000;
   localparam logic [2:0] MODE_INIT    = 3'b101;
   localparam logic [2:0] MODE_STARTUP = 3'b110;

   typedef enum logic [1:0] {
      SH_DEST     = 2'b00,
      SH_SELF     = 2'b01,
      SH_ALL      = 2'b10,
      SH_OTHERS   = 2'b11
   } shorthand_e;

   typedef struct packed {
      shorthand_e  sh;
      logic        level;
      logic        logical;
      logic [2:0]  mode;
      logic [7:0]  vec;
   } ipi_cmd_t;

   localparam logic [7:0] DEST_BROADCAST = 8'hFF;
endpackage

// File: rtl/ipi_field_decode.sv
module ipi_field_decode
   import ipi_pkg::*;
(
   input  logic [31:0] word,
   output ipi_cmd_t    cmd
);
   always_comb begin
      cmd.vec     = word[7:0];
      cmd.mode    = word[10:8];
      cmd.logical = word[11];
      cmd.level   = word[14];
      cmd.sh      = shorthand_e'(word[19:18]);
   end
endmodule

// File: rtl/ipi_target_expand.sv
module ipi_target_expand
   import ipi_pkg::*;
#(
   parameter int N    = 4,
   parameter int ID_W = (N > 1) ? $clog2(N) : 1
)(
   input  shorthand_e      sh,
   input  logic            logical,
   input  logic [7:0]      dest,
   input  logic [ID_W-1:0] self_id,
   output logic [N-1:0]    mask
);
   logic bcast;
   assign bcast = (dest == DEST_BROADCAST);

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic is_self, dest_hit;
      assign is_self  = (self_id == ID_W'(i));
      assign dest_hit = logical ? dest[i] : (bcast || (dest == 8'(i)));
      always_comb begin
         unique case (sh)
            SH_DEST:   mask[i] = dest_hit;
            SH_SELF:   mask[i] = is_self;
            SH_ALL:    mask[i] = 1'b1;
            SH_OTHERS: mask[i] = !is_self;
            default:   mask[i] = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/ipi_launch_ctrl.sv
module ipi_launch_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic lo_wr,
   input  logic accept_in,
   output logic launch,
   output logic pending
);
   assign launch = lo_wr && !pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    pending <= 1'b0;
      else if (launch)               pending <= 1'b1;
      else if (pending && accept_in) pending <= 1'b0;
   end

   // R3: an idle trigger makes the block busy
   a_r3_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_wr && !pending) |=> pending);
   // R2: nothing starts without a low-half write
   a_r2_no_spont: assert property (@(posedge clk) disable iff (!rst_n)
      (!pending && !lo_wr) |=> !pending);
   // R4: busy persists until accepted
   a_r4_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !accept_in) |=> pending);
endmodule

// File: rtl/ipi_cmd_reg.sv
module ipi_cmd_reg
   import ipi_pkg::*;
#(
   parameter int          N      = 4,
   parameter int          ID_W   = (N > 1) ? $clog2(N) : 1,
   parameter int          ADDR_W = 12,
   parameter logic [11:0] LO_OFS = 12'h300,
   parameter logic [11:0] HI_OFS = 12'h310
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ID_W-1:0]   self_id,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [31:0]       rd_data,
   output logic              msg_valid,
   input  logic              msg_ready,
   output logic [7:0]        msg_vector,
   output logic [2:0]        msg_mode,
   output logic              msg_logical,
   output logic              msg_level,
   output logic [N-1:0]      msg_targets,
   output logic [19:0]       start_addr
);
   localparam int PAGE_SHIFT = 12;

   initial begin
      if (N < 2 || N > 8) $error("ipi_cmd_reg: N must be within 2..8");
      if (ADDR_W < 12)    $error("ipi_cmd_reg: ADDR_W too narrow for offsets");
   end

   logic lo_wr, hi_wr, launch, pending;
   assign lo_wr = wr_en && (wr_addr == ADDR_W'(LO_OFS));
   assign hi_wr = wr_en && (wr_addr == ADDR_W'(HI_OFS));

   ipi_cmd_t      cmd_d, cmd_q;
   logic [7:0]    dest_q;
   logic [N-1:0]  mask_d, targets_q;

   ipi_field_decode u_dec (.word(wr_data), .cmd(cmd_d));

   ipi_target_expand #(.N(N), .ID_W(ID_W)) u_exp (
      .sh(cmd_d.sh), .logical(cmd_d.logical), .dest(dest_q),
      .self_id(self_id), .mask(mask_d));

   ipi_launch_ctrl u_ctl (
      .clk(clk), .rst_n(rst_n), .lo_wr(lo_wr), .accept_in(msg_ready),
      .launch(launch), .pending(pending));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dest_q    <= '0;
         cmd_q     <= '0;
         targets_q <= '0;
      end else begin
         if (hi_wr) dest_q <= wr_data[31:24];
         if (launch) begin
            cmd_q     <= cmd_d;
            targets_q <= mask_d;
         end
      end
   end

   assign msg_valid   = pending;
   assign msg_vector  = cmd_q.vec;
   assign msg_mode    = cmd_q.mode;
   assign msg_logical = cmd_q.logical;
   assign msg_level   = cmd_q.level;
   assign msg_targets = targets_q;
   assign start_addr  = (cmd_q.mode == MODE_STARTUP) ?
                        {cmd_q.vec, {PAGE_SHIFT{1'b0}}} : 20'h0;

   always_comb begin
      if (rd_addr == ADDR_W'(LO_OFS))
         rd_data = {12'h000, cmd_q.sh, 3'b000, cmd_q.level, 1'b0, pending,
                    cmd_q.logical, cmd_q.mode, cmd_q.vec};
      else if (rd_addr == ADDR_W'(HI_OFS))
         rd_data = {dest_q, 24'h0};
      else
         rd_data = 32'h0;
   end

   // R4: a waiting message keeps its valid flag and targets
   a_r4_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_targets)));
   // R5: a trigger while busy leaves the stored command alone
   a_r5_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_wr && pending) |=> $stable(cmd_q));
   // R6: all-but-self never includes the sender
   a_r6_excl_self: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && cmd_q.sh == SH_OTHERS) |-> !msg_targets[self_id]);
   // R7: self-only hits exactly one processor
   a_r7_self_one: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && cmd_q.sh == SH_SELF) |-> ($countones(msg_targets) == 1));
endmodule

// File: tb/ipi_cmd_reg_bench.sv
module ipi_cmd_reg_bench;
   localparam int N = 4;
   localparam int ID_W = 2;
   localparam int NV = 10;

   logic clk = 0, rst_n = 0;
   always #2 clk = ~clk;

   logic [ID_W-1:0] self_id = 2'd1;
   logic wr_en = 0, msg_ready = 0;
   logic [11:0] wr_addr = 0, rd_addr = 0;
   logic [31:0] wr_data = 0, rd_data;
   logic msg_valid, msg_logical, msg_level;
   logic [7:0] msg_vector;
   logic [2:0] msg_mode;
   logic [N-1:0] msg_targets;
   logic [19:0] start_addr;

   ipi_cmd_reg u_ipi_cmd_reg (.*);

   int tests = 0, fails = 0;
   bit done = 0;

   // columns: high word, low word, expected targets, expected start address
   localparam logic [31:0] V_HI [NV] = '{32'hFF000000, 32'hFF000000, 32'hFF000000,
      32'h02000000, 32'hFF000000, 32'h06000000, 32'h0A000000, 32'h0A000000,
      32'h0A000000, 32'h0A000000};
   localparam logic [31:0] V_LO [NV] = '{32'h000C4500, 32'h000C4611, 32'h000C4042,
      32'h00004031, 32'h00004055, 32'h00004077, 32'h00004877, 32'h00044020,
      32'h00084021, 32'h000C46A0};
   localparam logic [3:0] V_TG [NV] = '{4'b1101, 4'b1101, 4'b1101, 4'b0100,
      4'b1111, 4'b0000, 4'b1010, 4'b0010, 4'b1111, 4'b1101};
   localparam logic [19:0] V_SA [NV] = '{20'h0, 20'h11000, 20'h0, 20'h0, 20'h0,
      20'h0, 20'h0, 20'h0, 20'h0, 20'hA0000};
   localparam string V_REQ [NV] = '{"R6", "R10", "R6", "R8", "R8", "R8", "R9",
      "R7", "R7", "R10"};

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 0;
   endtask

   function automatic logic [31:0] rd(logic [11:0] a);
      rd_addr = a;
      return 32'h0;
   endfunction

   task automatic rdchk(string req, logic [11:0] a, logic [31:0] exp);
      rd_addr = a; #0.5;
      check(req, rd_data, exp);
   endtask

   task automatic accept();
      msg_ready = 1; @(negedge clk); msg_ready = 0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1 valid", 32'(msg_valid), 0);
      rdchk("R1 lo", 12'h300, 0);
      rdchk("R1 hi", 12'h310, 0);
      check("R1 start", 32'(start_addr), 0);

      // table walk
      for (int k = 0; k < NV; k++) begin
         wr(12'h310, V_HI[k]);
         check("R2 no launch on hi", 32'(msg_valid), 0);
         rdchk("R2 hi readback", 12'h310, {V_HI[k][31:24], 24'h0});
         wr(12'h300, V_LO[k]);
         check("R3 valid", 32'(msg_valid), 1);
         check("R3 vector", 32'(msg_vector), 32'(V_LO[k][7:0]));
         check("R3 mode", 32'(msg_mode), 32'(V_LO[k][10:8]));
         check("R3 logical", 32'(msg_logical), 32'(V_LO[k][11]));
         check("R3 level", 32'(msg_level), 32'(V_LO[k][14]));
         rdchk("R3 lo readback", 12'h300, (V_LO[k] & 32'h000C4FFF) | 32'h1000);
         check(V_REQ[k], 32'(msg_targets), 32'(V_TG[k]));
         check("R10 start", 32'(start_addr), 32'(V_SA[k]));
         accept();
         check("R4 cleared", 32'(msg_valid), 0);
         rdchk("R4 busy clear", 12'h300, V_LO[k] & 32'h000C4FFF);
      end

      // R4 hold without ready; R5 trigger while busy ignored
      wr(12'h310, 32'h03000000);
      wr(12'h300, 32'h00004033);
      repeat (3) @(negedge clk);
      check("R4 held valid", 32'(msg_valid), 1);
      check("R4 held targets", 32'(msg_targets), 32'h8);
      wr(12'h300, 32'h000C4611);
      check("R5 vector kept", 32'(msg_vector), 32'h33);
      check("R5 targets kept", 32'(msg_targets), 32'h8);
      check("R5 start kept", 32'(start_addr), 0);
      rdchk("R5 readback kept", 12'h300, 32'h00005033);
      accept();
      check("R5 no relaunch", 32'(msg_valid), 0);

      // R11 other offsets ignored
      wr(12'h320, 32'h000C4611);
      wr(12'h304, 32'hFFFFFFFF);
      check("R11 no launch", 32'(msg_valid), 0);
      rdchk("R11 lo kept", 12'h300, 32'h00004033);
      rdchk("R11 hi kept", 12'h310, 32'h03000000);
      rdchk("R11 other reads 0", 12'h320, 0);

      // R7 self-only with a different sender ID
      self_id = 2'd3;
      wr(12'h300, 32'h00044099);
      check("R7 self id3", 32'(msg_targets), 32'h8);
      accept();
      // R6 with sender 3
      wr(12'h300, 32'h000C4000);
      check("R6 others of id3", 32'(msg_targets), 32'h7);
      accept();

      // R1 reset mid-message
      wr(12'h300, 32'h000C4611);
      rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
      check("R1 valid after reset", 32'(msg_valid), 0);
      rdchk("R1 lo after reset", 12'h300, 0);
      check("R1 start after reset", 32'(start_addr), 0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule